// File: doc/BRIEF.md
# Capture/Compare Timer with PWM

A 16-bit up-counter runs from zero to a programmable limit, then returns to zero on the next clock. Two channels share this count. Each channel can do one of three jobs:

- **Capture:** store the count when a selected edge arrives on its input pin.
- **Compare:** act on its output pin when the count equals a stored value.
- **PWM:** combine the wrap of the counter with a compare match to produce a periodic waveform.

Channel 0 can also take over both channels' value registers as a double buffer. A new duty value then reaches the pin only at a counter wrap.

Software reaches the block through a byte-wide register bus. Writes take one clock and reads are combinational. An input strobe clears the counter and holds it at zero while asserted. Software is expected to clear the counter before it writes a new limit. Each channel raises a sticky event flag and an interrupt request when that flag is enabled.

Top module: `cct_top`

## Requirements
- R1: After reset the limit register reads 0xFFFF, both control bytes read 0x00, the count reads 0, and every pin output, pin enable and interrupt line is 0.
- R2: While `cnt_clr_i` is low, the count increases by one per clock and goes to 0 on the clock after it equals the limit. While `cnt_clr_i` is high, the count is 0 on the next clock.
- R3: Control byte layout: bit 7 flag, bit 6 interrupt enable, bit 5 mode B, bit 4 mode A, bits 3:2 edge/level select, bit 1 toggle-on-wrap, bit 0 full-duty. With mode B:A = 00, the channel is in capture mode. Edge select 01 captures rising edges, 10 captures falling edges, and 11 captures both. On an active edge the channel loads the count held one clock after the pin register first sees the new level, and sets the flag.
- R4: Writing the control byte with bit 7 = 0 clears the flag. Writing bit 7 = 1 leaves the flag unchanged. `irq_o[i]` is 1 exactly when channel i has both its flag and its interrupt enable set.
- R5: With mode B:A = 01 the channel is in compare mode. When the count equals the channel value, the flag is set and the pin acts according to the edge/level select: 01 toggles, 10 drives low, 11 drives high. With select 00 the pin enable output is 0.
- R6: In compare mode with toggle-on-wrap set and select 01, the pin toggles at every counter wrap.
- R7: In compare mode with toggle-on-wrap set and select 10, the block produces PWM. The pin goes high at each wrap and low after the count passes the value, giving value+1 high clocks per period. A value equal to the limit gives 100% duty, and a value above the limit keeps the pin low.
- R8: The full-duty bit, with select 10 or 11 in compare mode, holds the pin at the opposite of the compare level (high for select 10).
- R9: Channel 1 control bit 5 always reads 0, and writes to it have no effect.
- R10: With channel 0 bit 5 = 1 (buffered), channel 0 compares against a copy loaded at each wrap. The copy comes from whichever channel value register had its low byte written last. In this mode channel 1's pin enable is 0 and its flag is never set by the count.

Register addresses (bus_addr_i): 0 limit high, 1 limit low, 2 count high, 3 count low, 4 ch0 control, 5 ch0 value high, 6 ch0 value low, 7 ch1 control, 8 ch1 value high, 9 ch1 value low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clr_i | input | 1 | Counter clear strobe |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| cap_pin_i | input | 2 | Per-channel capture inputs |
| cmp_pin_o | output | 2 | Per-channel output pins |
| cmp_oe_o | output | 2 | Per-channel pin enables |
| irq_o | output | 2 | Per-channel interrupt requests |

## Verification
The bench builds the block with its default parameters: a 16-bit count and two channels. The limit is programmed at run time to small values such as 4, 5, 7, 9 and 19. This makes many wraps happen within a few hundred clocks. It brings the PWM duty boundaries within reach: value 0, value equal to the limit, and value above it. It also brings the wrap-aligned hand-over of buffered values within reach. With the limit left at 0xFFFF, capture and single-shot compare can run without a wrap getting in the way.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int CH_N   = 2;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_LIM_H = 4'd0;
    localparam logic [ADDR_W-1:0] A_LIM_L = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_H = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_L = 4'd3;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 4'd4;
    localparam int                CH_STRIDE = 3;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       ms_b;
        logic       ms_a;
        logic [1:0] els;
        logic       tov;
        logic       full;
    } chan_ctl_t;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        wrap_o = (st_q.cnt == lim_i) && !clr_i;
        if (clr_i)       st_d.cnt = '0;
        else if (wrap_o) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0)); // R2
    AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wrap_o) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2
endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int W     = 16,
    parameter bit HAS_B = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] lim_i,
    input  logic [W-1:0] cmp_i,
    input  logic         wrap_i,
    input  logic         slave_i,
    input  logic         ctl_we_i,
    input  logic         vh_we_i,
    input  logic         vl_we_i,
    input  logic [7:0]   wdata_i,
    input  logic         pin_i,
    output logic [7:0]   ctl_o,
    output logic [W-1:0] val_o,
    output logic         out_o,
    output logic         oe_o,
    output logic         irq_o,
    output logic         buf_o
);
    typedef struct packed {
        chan_ctl_t    ctl;
        logic [W-1:0] val;
        logic         pin_s;
        logic         pin_p;
        logic         out;
    } ch_state_t;

    ch_state_t st_q, st_d;
    logic rise, fall, is_cap, is_cmp, cap_hit, match, pwm, lvl;

    always_comb begin
        st_d    = st_q;
        rise    = st_q.pin_s & ~st_q.pin_p;
        fall    = ~st_q.pin_s & st_q.pin_p;
        is_cap  = !slave_i && !st_q.ctl.ms_b && !st_q.ctl.ms_a;
        is_cmp  = !slave_i && (st_q.ctl.ms_b || st_q.ctl.ms_a);
        cap_hit = is_cap && ((st_q.ctl.els[0] && rise) || (st_q.ctl.els[1] && fall));
        match   = is_cmp && (cnt_i == cmp_i);
        pwm     = st_q.ctl.tov && st_q.ctl.els[1];
        lvl     = st_q.ctl.els[0];

        st_d.pin_s = pin_i;
        st_d.pin_p = st_q.pin_s;

        if (ctl_we_i) begin
            st_d.ctl.ie   = wdata_i[6];
            st_d.ctl.ms_b = HAS_B ? wdata_i[5] : 1'b0;
            st_d.ctl.ms_a = wdata_i[4];
            st_d.ctl.els  = wdata_i[3:2];
            st_d.ctl.tov  = wdata_i[1];
            st_d.ctl.full = wdata_i[0];
            if (!wdata_i[7]) st_d.ctl.flag = 1'b0;
        end
        if (vh_we_i) st_d.val[W-1:8] = wdata_i[W-9:0];
        if (vl_we_i) st_d.val[7:0]   = wdata_i;
        if (cap_hit) st_d.val = cnt_i;
        if (cap_hit || match) st_d.ctl.flag = 1'b1;

        if (is_cmp) begin
            if (st_q.ctl.els[1] && st_q.ctl.full) begin
                st_d.out = ~lvl;
            end else if (pwm && wrap_i) begin
                st_d.out = (cmp_i <= lim_i) ? ~lvl : lvl;
            end else if (match) begin
                unique case (st_q.ctl.els)
                    2'b01:   st_d.out = ~st_q.out;
                    2'b10:   st_d.out = 1'b0;
                    2'b11:   st_d.out = 1'b1;
                    default: st_d.out = st_q.out;
                endcase
            end else if (wrap_i && st_q.ctl.tov) begin
                st_d.out = ~st_q.out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o = st_q.ctl;
    assign val_o = st_q.val;
    assign out_o = st_q.out;
    assign oe_o  = is_cmp && (st_q.ctl.els != 2'b00);
    assign irq_o = st_q.ctl.flag & st_q.ctl.ie;
    assign buf_o = st_q.ctl.ms_b;

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (val_o == $past(cnt_i))); // R3
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match || cap_hit) |=> ctl_o[7]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[7] && !ctl_we_i) |=> ctl_o[7]); // R4
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && st_q.ctl.full && st_q.ctl.els[1]) |=> (out_o == !$past(lvl))); // R8
endmodule

// File: rtl/cct_top.sv
module cct_top
    import cct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic [CH_N-1:0]   cap_pin_i,
    output logic [CH_N-1:0]   cmp_pin_o,
    output logic [CH_N-1:0]   cmp_oe_o,
    output logic [CH_N-1:0]   irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] act;
        logic             sel;
    } top_state_t;

    top_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [7:0]       ch_ctl [CH_N];
    logic [CNT_W-1:0] ch_val [CH_N];
    logic [CNT_W-1:0] ch_cmp [CH_N];
    logic [CH_N-1:0]  ctl_we, vh_we, vl_we, buf_bits;
    logic             buf_on;

    assign buf_on = buf_bits[0];

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr_i), .lim_i(st_q.lim),
        .cnt_o(cnt), .wrap_o(wrap)
    );

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = A_CH_BASE + ADDR_W'(i * CH_STRIDE);
        assign ctl_we[i] = bus_we_i && (bus_addr_i == BASE);
        assign vh_we[i]  = bus_we_i && (bus_addr_i == BASE + 4'd1);
        assign vl_we[i]  = bus_we_i && (bus_addr_i == BASE + 4'd2);
        assign ch_cmp[i] = (i == 0 && buf_on) ? st_q.act : ch_val[i];

        cct_channel #(.W(CNT_W), .HAS_B(i == 0)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .lim_i(st_q.lim),
            .cmp_i(ch_cmp[i]), .wrap_i(wrap), .slave_i(i != 0 && buf_on),
            .ctl_we_i(ctl_we[i]), .vh_we_i(vh_we[i]), .vl_we_i(vl_we[i]),
            .wdata_i(bus_wdata_i), .pin_i(cap_pin_i[i]),
            .ctl_o(ch_ctl[i]), .val_o(ch_val[i]), .out_o(cmp_pin_o[i]),
            .oe_o(cmp_oe_o[i]), .irq_o(irq_o[i]), .buf_o(buf_bits[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_we_i && bus_addr_i == A_LIM_H) st_d.lim[CNT_W-1:8] = bus_wdata_i;
        if (bus_we_i && bus_addr_i == A_LIM_L) st_d.lim[7:0]       = bus_wdata_i;
        if (vl_we[0]) st_d.sel = 1'b0;
        if (vl_we[1]) st_d.sel = 1'b1;
        if (!buf_on)   st_d.act = ch_val[0];
        else if (wrap) st_d.act = st_q.sel ? ch_val[1] : ch_val[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lim: '1, act: '0, sel: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = 8'h00;
        unique case (bus_addr_i)
            A_LIM_H: bus_rdata_o = st_q.lim[CNT_W-1:8];
            A_LIM_L: bus_rdata_o = st_q.lim[7:0];
            A_CNT_H: bus_rdata_o = cnt[CNT_W-1:8];
            A_CNT_L: bus_rdata_o = cnt[7:0];
            4'd4:    bus_rdata_o = ch_ctl[0];
            4'd5:    bus_rdata_o = ch_val[0][CNT_W-1:8];
            4'd6:    bus_rdata_o = ch_val[0][7:0];
            4'd7:    bus_rdata_o = ch_ctl[1];
            4'd8:    bus_rdata_o = ch_val[1][CNT_W-1:8];
            4'd9:    bus_rdata_o = ch_val[1][7:0];
            default: bus_rdata_o = 8'h00;
        endcase
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_on && !wrap) |=> $stable(st_q.act)); // R10
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_on && !ctl_we[1] && !ch_ctl[1][7]) |=> !ch_ctl[1][7]); // R10
endmodule

// File: tb/cct_top_tb_top.sv
`timescale 1ns/1ps
module cct_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] pin = '0;
    logic [1:0] pout, oe, irq;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // limit, compare value, expected high clocks per period
    localparam logic [47:0] PWM_TAB [5] = '{
        {16'd9,  16'd3,  16'd4},
        {16'd9,  16'd9,  16'd10},
        {16'd9,  16'd12, 16'd0},
        {16'd4,  16'd0,  16'd1},
        {16'd15, 16'd7,  16'd8}
    };

    always #2.5 clk = ~clk;

    cct_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_clr_i(clr), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cap_pin_i(pin), .cmp_pin_o(pout), .cmp_oe_o(oe), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; #0.1; d = rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic set_lim(input logic [15:0] m);
        clr = 1'b1;
        wr(4'd0, m[15:8]);
        wr(4'd1, m[7:0]);
        clr = 1'b0;
    endtask

    task automatic wr_val(input int ch, input logic [15:0] v);
        wr(4'(5 + 3 * ch), v[15:8]);
        wr(4'(6 + 3 * ch), v[7:0]);
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] b, h, l;
        int hi;
        logic a0, a1, prev;
        @(negedge clk);
        // R1 reset state
        rd(4'd0, b); chk("R1 lim high", b, 8'hFF);
        rd(4'd1, b); chk("R1 lim low", b, 8'hFF);
        rd(4'd4, b); chk("R1 ch0 ctl", b, 0);
        rd(4'd7, b); chk("R1 ch1 ctl", b, 0);
        rd(4'd3, b); chk("R1 count", b, 0);
        chk("R1 pins/oe/irq", {pout, oe, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 wrap at limit 5
        set_lim(16'd5);
        tick(8);
        rd(4'd3, b); chk("R2 wrap count", b, 2);
        clr = 1'b1; tick(1); clr = 1'b0;
        rd(4'd3, b); chk("R2 clear strobe", b, 0);

        // PWM table walk, R7
        for (int k = 0; k < 5; k++) begin
            logic [15:0] m, c, e;
            {m, c, e} = PWM_TAB[k];
            set_lim(m);
            wr_val(0, c);
            wr(4'd4, 8'h1A);
            tick(3 * (int'(m) + 1));
            hi = 0;
            for (int s = 0; s <= int'(m); s++) begin
                hi += int'(pout[0]); tick(1);
            end
            chk($sformatf("R7 pwm vector %0d", k), hi, int'(e));
        end

        // R8 full duty with value beyond limit
        set_lim(16'd9);
        wr_val(0, 16'd12);
        wr(4'd4, 8'h1B);
        tick(2);
        hi = 0;
        for (int s = 0; s < 10; s++) begin hi += int'(pout[0]); tick(1); end
        chk("R8 full duty", hi, 10);

        // R6 toggle on wrap
        set_lim(16'd7);
        wr_val(0, 16'h00FF);
        wr(4'd4, 8'h16);
        tick(3);
        a0 = pout[0]; tick(8); a1 = pout[0];
        chk("R6 toggled after one wrap", a1, !a0);
        tick(8);
        chk("R6 back after two wraps", pout[0], a0);

        // R5 compare: set, toggle, release
        set_lim(16'hFFFF);
        wr(4'd4, 8'h1C);
        wr_val(0, 16'h0040);
        tick(80);
        chk("R5 set on match", pout[0], 1);
        rd(4'd4, b); chk("R5 flag on match", b[7], 1);
        wr(4'd4, 8'h14);
        wr_val(0, 16'h00A0);
        tick(100);
        chk("R5 toggle on match", pout[0], 0);
        rd(4'd4, b); chk("R5 flag after toggle", b, 8'h94);
        chk("R5 oe driven", oe[0], 1);
        wr(4'd4, 8'h10);
        chk("R5 released pin", oe[0], 0);

        // R3 capture
        wr(4'd4, 8'h04);
        pin[0] = 1'b0; tick(3);
        pin[0] = 1'b1; tick(1);
        rd(4'd2, h); rd(4'd3, l);
        tick(1);
        rd(4'd5, b); chk("R3 rising capture high", b, h);
        rd(4'd6, b); chk("R3 rising capture low", b, l);
        rd(4'd4, b); chk("R3 flag on capture", b, 8'h84);
        wr(4'd4, 8'h04);
        pin[0] = 1'b0; tick(4);
        rd(4'd4, b); chk("R3 falling ignored", b, 8'h04);
        wr(4'd4, 8'h0C);
        pin[0] = 1'b1; tick(1);
        rd(4'd3, l); tick(1);
        rd(4'd6, b); chk("R3 either edge capture", b, l);

        // R4 sticky flag and interrupt
        wr(4'd4, 8'hCC);
        rd(4'd4, b); chk("R4 write one keeps flag", b, 8'hCC);
        chk("R4 irq raised", irq[0], 1);
        wr(4'd4, 8'h4C);
        rd(4'd4, b); chk("R4 write zero clears", b, 8'h4C);
        chk("R4 irq dropped", irq[0], 0);
        wr(4'd4, 8'h00);

        // R9 channel 1 has no mode B bit
        wr(4'd7, 8'hFF);
        rd(4'd7, b); chk("R9 ch1 bit5", b, 8'h5F);
        wr(4'd7, 8'h00);

        // R10 buffered
        wr_val(0, 16'd4);
        set_lim(16'd19);
        wr(4'd4, 8'h2A);
        tick(60);
        prev = pout[0];
        for (int g = 0; g < 40; g++) begin
            if (!prev && pout[0]) break;
            prev = pout[0]; tick(1);
        end
        wr(4'd9, 8'd9);
        hi = 0;
        for (int s = 0; s < 19; s++) begin hi += int'(pout[0]); tick(1); end
        chk("R10 old value until wrap", hi, 4);
        hi = 0;
        for (int s = 0; s < 20; s++) begin hi += int'(pout[0]); tick(1); end
        chk("R10 new value after wrap", hi, 10);
        chk("R10 ch1 pin released", oe[1], 0);
        rd(4'd7, b); chk("R10 ch1 flag quiet", b, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule